// File: doc/BRIEF.md
# Non-Blocking Write-Back Data Cache

This block is a small write-back data cache that sits between a processor request port and a memory port that moves whole lines of four words. On the processor side it accepts loads, which carry a word address and a request tag, and stores, which carry a word address and a data word. A load is answered with the tag and the data word. The memory side issues line reads and line writes and takes back line data. A miss does not block the cache. Up to a parameterised number of line fills can be outstanding at once. Each outstanding fill owns a small queue of accesses that wait for that line.

A primary miss reserves a miss slot, records its access as the first queue entry, starts a line read and clears the direct-mapped slot it will refill. If that slot held modified data, the old line moves into a one-line eviction buffer, which later drains as a line write. A secondary miss to a line that is already being fetched only adds an entry to that line's queue. A returning line always belongs to the oldest outstanding miss slot. The line is installed and its queued accesses are then applied one per cycle in arrival order. Replies can therefore come back in a different order from the requests, and the processor matches them by tag.

A fixed-priority scheduler runs one action per cycle. The order is: queued-access replay, then line installation, then eviction drain, then a new processor request.

Top module: `nbc_cache`

## Requirements
- R1: A load that hits returns a reply, with the request tag and the stored word at offset addr[1:0] of the line, on the clock edge after it is accepted.
- R2: A store that hits updates the addressed word and marks the line modified. A later eviction of that line writes it to memory with the updated word.
- R3: A primary miss issues a line read (mem_req_wr=0) whose line address is cpu_req_addr[AW-1:2]. If the slot it replaces is modified, that line is later written back (mem_req_wr=1) with its own line address and contents.
- R4: Accesses to a line whose fill is pending are queued behind the primary access and applied in arrival order once the line arrives. Queued loads reply in that order, and a queued store is visible to the queued loads behind it.
- R5: A new request is accepted only when it can complete its path. A hit always qualifies. A secondary miss needs a free entry in its line's queue. A primary miss needs a free miss slot, an empty memory request register and an empty eviction buffer, and it must not share a cache index with a different pending line. Otherwise cpu_req_ready stays low.
- R6: Miss slots are used in circular order, and each returned line is installed for the oldest outstanding miss.
- R7: Priority from highest to lowest is replay, line installation, eviction drain, processor request. While a returned line is offered, no processor request is accepted. While a replay runs, neither cpu_req_ready nor mem_rsp_ready is high.
- R8: A memory request stays valid, with address and direction unchanged, until mem_req_ready is seen.
- R9: Replies may be out of order with respect to requests. Every accepted load receives exactly one reply, carrying its own tag and the value defined by the sequential order of accepted requests.
- R10: After reset no output valid is high, and every line is invalid, so the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_wr | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | AW (8) | Word address |
| cpu_req_tag | input | TW (4) | Load tag |
| cpu_req_data | input | DW (16) | Store data |
| cpu_rsp_valid | output | 1 | Load reply valid (one cycle) |
| cpu_rsp_tag | output | TW (4) | Tag of the answered load |
| cpu_rsp_data | output | DW (16) | Loaded word |
| mem_req_valid | output | 1 | Line request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_wr | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | AW-2 (6) | Line address |
| mem_req_line | output | 4*DW (64) | Write line, word w at bits [w*DW +: DW] |
| mem_rsp_valid | input | 1 | Returned line present |
| mem_rsp_ready | output | 1 | Returned line taken |
| mem_rsp_line | input | 4*DW (64) | Returned line, same packing |

## Verification
The hardest condition to reach is a full replay queue that coexists with an occupied second miss slot, a blocked memory request register and a pending third miss. Under these conditions the acceptance rules, slot ordering and reply ordering all come into play together. The bench reaches this state by holding the memory model's responses and request acceptance under its own control, then building the queue entry by entry. It then releases the memory and compares the exact reply tag sequence. Broad sweeps across every address and a long random phase, with random memory stalls over a small conflict-heavy address range, check each reply against a flat sequential memory model.

// File: rtl/nbc_pkg.sv
// Shared definitions for the non-blocking cache.
// Assumes: nothing beyond the default geometry constants below.
package nbc_pkg;
    localparam int NBC_AW    = 8;   // word address bits
    localparam int NBC_DW    = 16;  // data word bits
    localparam int NBC_TW    = 4;   // load tag bits
    localparam int NBC_LINES = 8;   // direct-mapped lines
    localparam int NBC_NMISS = 2;   // outstanding fills
    localparam int NBC_RQD   = 4;   // queue entries per fill

    // one action per cycle, listed by falling priority
    typedef enum logic [1:0] {
        ACT_REPLAY = 2'd0,
        ACT_FILL   = 2'd1,
        ACT_WB     = 2'd2,
        ACT_CPU    = 2'd3
    } nbc_act_t;
endpackage

// File: rtl/nbc_miss_file.sv
// Miss slots with per-slot replay queues.
// Slots are allocated and retired in circular order, so the oldest slot
// always owns the next returning line. Entries are opaque EW-bit words.
// Assumes: the caller never pushes into a full queue, never allocates a
// busy slot and never retires an empty one.
module nbc_miss_file #(
    parameter int LAW   = 6,
    parameter int IW    = 3,
    parameter int NMISS = 2,
    parameter int RQD   = 4,
    parameter int EW    = 23,
    localparam int MIW  = (NMISS > 1) ? $clog2(NMISS) : 1,
    localparam int QCW  = $clog2(RQD + 1),
    localparam int PW   = (RQD > 1) ? $clog2(RQD) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] lk_line,
    output logic           lk_hit,
    output logic [MIW-1:0] lk_idx,
    output logic           lk_qfull,
    output logic           lk_conflict,
    output logic           free_avail,
    input  logic           alloc_en,
    input  logic           push_en,
    input  logic [MIW-1:0] push_idx,
    input  logic [EW-1:0]  push_ent,
    output logic           old_valid,
    output logic [LAW-1:0] old_line,
    output logic [QCW-1:0] old_cnt,
    input  logic [PW-1:0]  rd_pos,
    output logic [EW-1:0]  rd_ent,
    input  logic           retire_en
);
    logic [NMISS-1:0] vld;
    logic [LAW-1:0]   line_q [NMISS];
    logic [QCW-1:0]   cnt_q  [NMISS];
    logic [EW-1:0]    ent_q  [NMISS][RQD];
    logic [MIW-1:0]   wr_ptr, rd_ptr;

    // associative match of the requested line against live slots
    always_comb begin
        lk_hit      = 1'b0;
        lk_idx      = '0;
        lk_conflict = 1'b0;
        for (int i = 0; i < NMISS; i++) begin
            if (vld[i] && line_q[i] == lk_line) begin
                lk_hit = 1'b1;
                lk_idx = MIW'(i);
            end
            if (vld[i] && line_q[i] != lk_line && line_q[i][IW-1:0] == lk_line[IW-1:0])
                lk_conflict = 1'b1;
        end
    end

    assign lk_qfull   = (cnt_q[lk_idx] == QCW'(RQD));
    assign free_avail = !vld[wr_ptr];
    assign old_valid  = vld[rd_ptr];
    assign old_line   = line_q[rd_ptr];
    assign old_cnt    = cnt_q[rd_ptr];
    assign rd_ent     = ent_q[rd_ptr][rd_pos];

    // slot control: valid bits, line addresses, counts, circular pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < NMISS; i++) begin
                cnt_q[i]  <= '0;
                line_q[i] <= '0;
            end
        end else begin
            if (alloc_en) begin
                vld[wr_ptr]    <= 1'b1;
                line_q[wr_ptr] <= lk_line;
                cnt_q[wr_ptr]  <= QCW'(1);
                wr_ptr         <= (wr_ptr == MIW'(NMISS - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (push_en)
                cnt_q[push_idx] <= cnt_q[push_idx] + 1'b1;
            if (retire_en) begin
                vld[rd_ptr]   <= 1'b0;
                cnt_q[rd_ptr] <= '0;
                rd_ptr        <= (rd_ptr == MIW'(NMISS - 1)) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    // queue storage: the first entry on allocation, later ones appended
    always_ff @(posedge clk) begin
        if (alloc_en)
            ent_q[wr_ptr][0] <= push_ent;
        if (push_en)
            ent_q[push_idx][cnt_q[push_idx][PW-1:0]] <= push_ent;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (cnt_q[push_idx] < QCW'(RQD)));
    // R6
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !vld[wr_ptr]);
    // R6
    retire_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_en |-> vld[rd_ptr]);
endmodule

// File: rtl/nbc_victim_buf.sv
// Single-line holding register for a modified line that awaits write-back.
// Assumes: load only when empty; clear and load never in the same cycle.
module nbc_victim_buf #(
    parameter int LAW = 6,
    parameter int LW  = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [LAW-1:0] load_addr,
    input  logic [LW-1:0]  load_line,
    input  logic           clear_en,
    output logic           full,
    output logic [LAW-1:0] addr,
    output logic [LW-1:0]  line
);
    // occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n)        full <= 1'b0;
        else if (load_en)  full <= 1'b1;
        else if (clear_en) full <= 1'b0;
    end

    // payload capture
    always_ff @(posedge clk) begin
        if (load_en) begin
            addr <= load_addr;
            line <= load_line;
        end
    end

    // R3
    vb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !full);
endmodule

// File: rtl/nbc_line_store.sv
// Direct-mapped line array with valid, modified and tag state.
// One read port (combinational) and, per cycle, at most one of: word write,
// line install, invalidate. Assumes the caller serialises these.
module nbc_line_store #(
    parameter int LINES = 8,
    parameter int LTW   = 3,
    parameter int DW    = 16,
    localparam int IW   = $clog2(LINES),
    localparam int LW   = 4 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  rd_idx,
    output logic           rd_valid,
    output logic           rd_dirty,
    output logic [LTW-1:0] rd_tag,
    output logic [LW-1:0]  rd_line,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [1:0]     wr_off,
    input  logic [DW-1:0]  wr_data,
    input  logic           fill_en,
    input  logic [IW-1:0]  fill_idx,
    input  logic [LTW-1:0] fill_tag,
    input  logic [LW-1:0]  fill_line,
    input  logic           inval_en,
    input  logic [IW-1:0]  inval_idx
);
    logic [LINES-1:0] vld, dty;
    logic [LTW-1:0]   tag_q  [LINES];
    logic [LW-1:0]    data_q [LINES];

    assign rd_valid = vld[rd_idx];
    assign rd_dirty = dty[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    // line state bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            dty <= '0;
        end else begin
            if (fill_en) begin
                vld[fill_idx] <= 1'b1;
                dty[fill_idx] <= 1'b0;
            end
            if (wr_en)    dty[wr_idx]    <= 1'b1;
            if (inval_en) vld[inval_idx] <= 1'b0;
        end
    end

    // tags and data words
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end
        if (wr_en)
            data_q[wr_idx][wr_off*DW +: DW] <= wr_data;
    end
endmodule

// File: rtl/nbc_cache.sv
// Non-blocking write-back cache top: priority scheduler, replay engine,
// hit path, miss entry, eviction drain and the registered memory request.
// Assumes: the memory returns line reads in issue order and performs line
// requests in issue order; load tags in flight are unique.
module nbc_cache
    import nbc_pkg::*;
#(
    parameter int AW    = NBC_AW,
    parameter int DW    = NBC_DW,
    parameter int TW    = NBC_TW,
    parameter int LINES = NBC_LINES,
    parameter int NMISS = NBC_NMISS,
    parameter int RQD   = NBC_RQD,
    localparam int LAW  = AW - 2,
    localparam int LW   = 4 * DW,
    localparam int IW   = $clog2(LINES),
    localparam int LTW  = LAW - IW,
    localparam int EW   = 1 + 2 + TW + DW,
    localparam int MIW  = (NMISS > 1) ? $clog2(NMISS) : 1,
    localparam int QCW  = $clog2(RQD + 1),
    localparam int PW   = (RQD > 1) ? $clog2(RQD) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req_valid,
    output logic           cpu_req_ready,
    input  logic           cpu_req_wr,
    input  logic [AW-1:0]  cpu_req_addr,
    input  logic [TW-1:0]  cpu_req_tag,
    input  logic [DW-1:0]  cpu_req_data,
    output logic           cpu_rsp_valid,
    output logic [TW-1:0]  cpu_rsp_tag,
    output logic [DW-1:0]  cpu_rsp_data,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_wr,
    output logic [LAW-1:0] mem_req_addr,
    output logic [LW-1:0]  mem_req_line,
    input  logic           mem_rsp_valid,
    output logic           mem_rsp_ready,
    input  logic [LW-1:0]  mem_rsp_line
);
    // request decode
    logic [1:0]     c_off;
    logic [LAW-1:0] c_line;
    logic [IW-1:0]  c_idx;
    logic [LTW-1:0] c_ltag;
    assign c_off  = cpu_req_addr[1:0];
    assign c_line = cpu_req_addr[AW-1:2];
    assign c_idx  = c_line[IW-1:0];
    assign c_ltag = c_line[LAW-1:IW];

    // replay state
    logic          rp_active;
    logic [PW-1:0] rp_pos;

    // submodule wiring
    logic           lk_hit, lk_qfull, lk_conflict, free_avail, old_valid;
    logic [MIW-1:0] lk_idx;
    logic [LAW-1:0] old_line;
    logic [QCW-1:0] old_cnt;
    logic [EW-1:0]  rd_ent, new_ent;
    logic           ls_valid, ls_dirty;
    logic [LTW-1:0] ls_tag;
    logic [LW-1:0]  ls_line;
    logic [IW-1:0]  old_idx, port_idx;
    logic           vb_full;
    logic [LAW-1:0] vb_addr;
    logic [LW-1:0]  vb_line;

    // replay entry fields: {wr, off, tag, data}
    logic          e_wr;
    logic [1:0]    e_off;
    logic [TW-1:0] e_tag;
    logic [DW-1:0] e_data;
    assign {e_wr, e_off, e_tag, e_data} = rd_ent;
    assign new_ent  = {cpu_req_wr, c_off, cpu_req_tag, cpu_req_data};
    assign old_idx  = old_line[IW-1:0];
    assign port_idx = rp_active ? old_idx : c_idx;

    // scheduler: one action per cycle, fixed priority
    nbc_act_t act;
    always_comb begin
        if (rp_active)                   act = ACT_REPLAY;
        else if (mem_rsp_valid)          act = ACT_FILL;
        else if (vb_full && !mem_req_valid) act = ACT_WB;
        else                             act = ACT_CPU;
    end

    // admission rule for a processor request
    logic hit, cpu_ok, cpu_fire, hit_fire, primary, secondary;
    logic do_replay, do_fill, do_wb, rp_last;
    always_comb begin
        hit    = ls_valid && (ls_tag == c_ltag);
        cpu_ok = hit
              || (lk_hit && !lk_qfull)
              || (!lk_hit && free_avail && !mem_req_valid && !vb_full && !lk_conflict);
    end
    assign cpu_req_ready = (act == ACT_CPU) && cpu_ok;
    assign cpu_fire      = cpu_req_ready && cpu_req_valid;
    assign hit_fire      = cpu_fire && hit;
    assign primary       = cpu_fire && !hit && !lk_hit;
    assign secondary     = cpu_fire && !hit && lk_hit;
    assign do_replay     = (act == ACT_REPLAY);
    assign do_fill       = (act == ACT_FILL);
    assign do_wb         = (act == ACT_WB);
    assign mem_rsp_ready = do_fill;
    assign rp_last       = (QCW'(rp_pos) + QCW'(1)) == old_cnt;

    nbc_miss_file #(.LAW(LAW), .IW(IW), .NMISS(NMISS), .RQD(RQD), .EW(EW)) u_miss (
        .clk(clk), .rst_n(rst_n),
        .lk_line(c_line), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_qfull(lk_qfull),
        .lk_conflict(lk_conflict), .free_avail(free_avail),
        .alloc_en(primary), .push_en(secondary), .push_idx(lk_idx), .push_ent(new_ent),
        .old_valid(old_valid), .old_line(old_line), .old_cnt(old_cnt),
        .rd_pos(rp_pos), .rd_ent(rd_ent),
        .retire_en(do_replay && rp_last)
    );

    nbc_line_store #(.LINES(LINES), .LTW(LTW), .DW(DW)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(port_idx), .rd_valid(ls_valid), .rd_dirty(ls_dirty),
        .rd_tag(ls_tag), .rd_line(ls_line),
        .wr_en((hit_fire && cpu_req_wr) || (do_replay && e_wr)),
        .wr_idx(port_idx),
        .wr_off(rp_active ? e_off : c_off),
        .wr_data(rp_active ? e_data : cpu_req_data),
        .fill_en(do_fill), .fill_idx(old_idx), .fill_tag(old_line[LAW-1:IW]),
        .fill_line(mem_rsp_line),
        .inval_en(primary), .inval_idx(c_idx)
    );

    nbc_victim_buf #(.LAW(LAW), .LW(LW)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .load_en(primary && ls_valid && ls_dirty),
        .load_addr({ls_tag, c_idx}), .load_line(ls_line),
        .clear_en(do_wb),
        .full(vb_full), .addr(vb_addr), .line(vb_line)
    );

    // replay engine: start on install, step per cycle, stop after last entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_active <= 1'b0;
            rp_pos    <= '0;
        end else if (do_fill) begin
            rp_active <= 1'b1;
            rp_pos    <= '0;
        end else if (do_replay) begin
            rp_active <= !rp_last;
            rp_pos    <= rp_last ? '0 : rp_pos + 1'b1;
        end
    end

    // memory request register: line read on primary miss, line write on drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_wr    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_line  <= '0;
        end else if (primary) begin
            mem_req_valid <= 1'b1;
            mem_req_wr    <= 1'b0;
            mem_req_addr  <= c_line;
        end else if (do_wb) begin
            mem_req_valid <= 1'b1;
            mem_req_wr    <= 1'b1;
            mem_req_addr  <= vb_addr;
            mem_req_line  <= vb_line;
        end else if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
        end
    end

    // reply register: hit loads and replayed loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_tag   <= '0;
            cpu_rsp_data  <= '0;
        end else begin
            cpu_rsp_valid <= (hit_fire && !cpu_req_wr) || (do_replay && !e_wr);
            if (do_replay) begin
                cpu_rsp_tag  <= e_tag;
                cpu_rsp_data <= ls_line[e_off*DW +: DW];
            end else begin
                cpu_rsp_tag  <= cpu_req_tag;
                cpu_rsp_data <= ls_line[c_off*DW +: DW];
            end
        end
    end

    // R8
    mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wr));
    // R7
    replay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_active |-> !cpu_req_ready && !mem_rsp_ready);
    // R6
    fill_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_ready |-> old_valid);
    // R1
    hit_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_fire && !cpu_req_wr |=> cpu_rsp_valid);
endmodule

// File: tb/nbc_cache_bench.sv
`timescale 1ns/100ps
module nbc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_wr = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [3:0]  cpu_req_tag = '0;
    logic [15:0] cpu_req_data = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [3:0]  cpu_rsp_tag;
    logic [15:0] cpu_rsp_data;
    logic        mem_req_valid, mem_req_wr, mem_rsp_ready;
    logic        mem_req_ready = 1'b1;
    logic [5:0]  mem_req_addr;
    logic [63:0] mem_req_line;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_line = '0;

    always #2.5 clk = ~clk;

    nbc_cache u_nbc_cache (.*);

    int n_chk = 0, n_fail = 0;
    logic [15:0] ref_mem [256];
    logic [15:0] dram    [256];
    logic [15:0] exp_d   [16];
    bit          pend    [16];
    int          rsp_seq [16];
    int          rsp_n = 0;
    logic [63:0] fifo [8];
    int          f_wr = 0, f_rd = 0;
    bit          hold = 0, rnd_en = 0, mstall = 0;
    int          r7_bad = 0;
    logic [5:0]  last_st_addr;
    logic [63:0] last_st_line;
    logic [15:0] lfsr = 16'hACE1;
    int          next_tag = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: handshakes for the coming edge, and outputs of the last edge
    always begin
        @(negedge clk); #2;
        if (rst_n) begin
            if (cpu_req_valid && cpu_req_ready) begin
                if (mem_rsp_valid) r7_bad++;
                if (cpu_req_wr) ref_mem[cpu_req_addr] = cpu_req_data;
                else begin
                    exp_d[cpu_req_tag] = ref_mem[cpu_req_addr];
                    pend[cpu_req_tag]  = 1;
                end
            end
            if (cpu_rsp_valid) begin
                // R1 hit replies and R4 replayed replies, R9 tag match
                chk(pend[cpu_rsp_tag] && cpu_rsp_data == exp_d[cpu_rsp_tag],
                    "R9 reply tag/data", {cpu_rsp_tag, cpu_rsp_data},
                    {cpu_rsp_tag, exp_d[cpu_rsp_tag]});
                pend[cpu_rsp_tag] = 0;
                rsp_seq[rsp_n % 16] = int'(cpu_rsp_tag);
                rsp_n++;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_wr) begin
                    for (int w = 0; w < 4; w++) dram[{mem_req_addr, 2'(w)}] = mem_req_line[w*16 +: 16];
                    last_st_addr = mem_req_addr;
                    last_st_line = mem_req_line;
                end else begin
                    for (int w = 0; w < 4; w++) fifo[f_wr % 8][w*16 +: 16] = dram[{mem_req_addr, 2'(w)}];
                    f_wr++;
                end
            end
            if (mem_rsp_valid && mem_rsp_ready) f_rd++;
        end
    end

    // memory model and random stall knobs
    always @(negedge clk) begin
        if (rnd_en) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hold   = lfsr[0] & lfsr[1];
            mstall = lfsr[2] & lfsr[3] & lfsr[4];
        end
        mem_req_ready <= !mstall;
        mem_rsp_valid <= (f_wr != f_rd) && !hold;
        mem_rsp_line  <= fifo[f_rd % 8];
    end

    task automatic cpu_op(input bit wr, input int a, input int t, input logic [15:0] d);
        bit r;
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_wr = wr; cpu_req_addr = 8'(a);
        cpu_req_tag = 4'(t); cpu_req_data = d;
        forever begin
            #1 r = cpu_req_ready;
            @(negedge clk);
            if (r) break;
        end
        cpu_req_valid = 0;
    endtask

    task automatic try_op(input bit wr, input int a, input int t, input int n, output bit acc);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_wr = wr; cpu_req_addr = 8'(a);
        cpu_req_tag = 4'(t); cpu_req_data = 16'h1234;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            #1 if (cpu_req_ready) acc = 1;
            @(negedge clk);
            if (acc) break;
        end
        cpu_req_valid = 0;
    endtask

    task automatic load_any(input int a);
        while (pend[next_tag]) @(negedge clk);
        cpu_op(0, a, next_tag, 16'h0);
        next_tag = (next_tag + 1) % 16;
    endtask

    task automatic drain();
        int any;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            any = 0;
            for (int t = 0; t < 16; t++) if (pend[t]) any = 1;
            if (!any && f_wr == f_rd && !mem_req_valid && i > 20) break;
        end
    endtask

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit acc;
        for (int a = 0; a < 256; a++) begin
            ref_mem[a] = 16'(a * 37 + 5);
            dram[a]    = 16'(a * 37 + 5);
        end
        for (int t = 0; t < 16; t++) pend[t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R10 reset state
        chk(!cpu_rsp_valid && !mem_req_valid && !mem_rsp_ready, "R10 idle outputs",
            {cpu_rsp_valid, mem_req_valid, mem_rsp_ready}, 0);

        // full queue, stalls and ordered replay
        hold = 1; mstall = 1;
        cpu_op(0, 8'h40, 1, 0);
        #1 chk(mem_req_valid && !mem_req_wr && mem_req_addr == 6'h10, "R3 line read",
               {mem_req_valid, mem_req_wr, mem_req_addr}, {2'b10, 6'h10});
        chk(rsp_n == 0, "R10 first access misses", rsp_n, 0);
        repeat (3) @(negedge clk);
        #1 chk(mem_req_valid && mem_req_addr == 6'h10, "R8 request held",
               {mem_req_valid, mem_req_addr}, {1'b1, 6'h10});
        mstall = 0;
        cpu_op(1, 8'h41, 0, 16'hAAAA);
        cpu_op(0, 8'h41, 2, 0);
        cpu_op(0, 8'h42, 3, 0);
        try_op(0, 8'h43, 4, 5, acc);
        chk(!acc, "R5 queue full stall", acc, 0);
        try_op(0, 8'h80, 4, 5, acc);
        chk(!acc, "R5 index conflict stall", acc, 0);
        cpu_op(0, 8'h84, 5, 0);
        try_op(0, 8'h88, 6, 5, acc);
        chk(!acc, "R5 no free miss slot", acc, 0);
        hold = 0;
        drain();
        chk(rsp_n == 4, "R4 reply count", rsp_n, 4);
        // R4 and R6: arrival order, oldest slot first
        chk(rsp_seq[0] == 1 && rsp_seq[1] == 2 && rsp_seq[2] == 3 && rsp_seq[3] == 5,
            "R4 replay order", {rsp_seq[0], rsp_seq[1], rsp_seq[2], rsp_seq[3]}, {32'd1, 32'd2, 32'd3, 32'd5});

        // R9: hit overtakes an outstanding miss
        rsp_n = 0; hold = 1;
        cpu_op(0, 8'h68, 6, 0);
        cpu_op(0, 8'h40, 7, 0);
        repeat (3) @(negedge clk);
        hold = 0;
        drain();
        chk(rsp_seq[0] == 7 && rsp_seq[1] == 6, "R9 out of order", {rsp_seq[0], rsp_seq[1]}, {32'd7, 32'd6});

        // R2: store hit, then eviction writes the updated line back
        cpu_op(1, 8'h40, 0, 16'h5555);
        rsp_n = 0;
        cpu_op(0, 8'h40, 8, 0);
        @(negedge clk);
        chk(rsp_n == 1, "R1 hit reply", rsp_n, 1);
        cpu_op(0, 8'h80, 9, 0);
        drain();
        chk(last_st_addr == 6'h10, "R3 victim address", last_st_addr, 6'h10);
        chk(last_st_line[15:0] == 16'h5555 && last_st_line[31:16] == 16'hAAAA,
            "R2 written-back line", last_st_line[31:0], 32'hAAAA5555);

        // sweeps over every address
        for (int a = 0; a < 256; a++) cpu_op(1, a, 0, 16'(a * 91 + 7) ^ 16'h3C3C);
        for (int a = 0; a < 256; a++) load_any(a);
        drain();

        // random phase with memory stalls
        rnd_en = 1;
        for (int i = 0; i < 2500; i++) begin
            logic [15:0] r = lfsr;
            if (r[8]) cpu_op(1, int'(r[5:0]) ^ int'(r[11:10]), 0, r ^ 16'(i));
            else      load_any(int'(r[5:0]) ^ int'(r[11:10]));
        end
        rnd_en = 0; hold = 0; mstall = 0;
        drain();
        for (int a = 0; a < 256; a++) load_any(a);
        drain();
        begin
            int left = 0;
            for (int t = 0; t < 16; t++) if (pend[t]) left++;
            chk(left == 0, "R9 every load answered", left, 0);
        end
        chk(r7_bad == 0, "R7 request beat a returned line", r7_bad, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule